// File: doc/BRIEF.md
# Port Statistics Command Engine

This block sits in front of a bank of per-port event counters and runs maintenance and readout commands on them. Each port owns a fixed set of counters. Every cycle, each counter may receive an increment pulse from the frame classification logic. A host drives the block through a single 16-bit operation word. It starts a command by writing that word with the top bit set, then polls the same bit until the command is done.

Four commands are available: clear every counter of every port, clear the counters of one port, copy the counters of one port into a snapshot buffer, and fetch one snapshot entry into a result register. Clears walk the counters one per cycle. A capture copies a whole port in a single cycle, so every value in the snapshot comes from the same instant. To read a full port, the host issues one capture and then fetches indices 0 up to the last index in turn. A two-bit histogram setting lives in the same word and survives every command.

Top module: `stat_op_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `op_rdata` is 0, `rd_data` is 0 and every counter is 0.
- R2: The operation word has this layout: bit 15 is start on write and busy on read. Bits [14:12] are the opcode, bits [11:10] the histogram setting, bits [9:5] the port field holding port+1, and bits [4:0] the counter index. After a command, `op_rdata` returns the opcode, port field and index of that command, with bit 15 equal to `busy`.
- R3: Every accepted write loads bits [11:10] into the histogram setting, whether or not bit 15 is set. No command changes that setting. A write with bit 15 clear starts nothing.
- R4: A write that arrives while `busy` is 1 is ignored entirely.
- R5: Opcode 1 (flush all) holds `busy` for NUM_PORTS*NUM_CTRS cycles and leaves every counter at 0.
- R6: Opcode 2 (flush port) with port field p+1 holds `busy` for NUM_CTRS cycles. It clears the counters of port p one per cycle, in index order, and no other counter is touched. An increment to a counter in the cycle that counter is cleared is dropped. An increment to a counter of that port that was already cleared still counts.
- R7: Opcode 5 (capture) with a valid port field holds `busy` for one cycle. It copies all counters of that port into the snapshot in that same cycle. Later increments do not change the snapshot.
- R8: Opcode 4 (read) holds `busy` for one cycle and loads snapshot entry [4:0] into `rd_data`. An index of NUM_CTRS or above loads 0. `rd_data` changes only through this command.
- R9: Opcodes 0, 3, 6 and 7, and a flush-port or capture whose port field is 0 or above NUM_PORTS, hold `busy` for one cycle. They change no counter and leave the snapshot unchanged.
- R10: A counter adds one for each cycle its increment input is 1 and stays at its maximum value 2^CTR_W-1 once it reaches it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_wr | input | 1 | Write strobe for the operation word |
| op_wdata | input | 16 | Operation word written by the host |
| op_rdata | output | 16 | Operation word readback, bit 15 is busy |
| busy | output | 1 | A command is in progress |
| inc | input | NUM_PORTS*NUM_CTRS | Increment pulses, bit p*NUM_CTRS+c for counter c of port p |
| rd_data | output | CTR_W | Snapshot entry fetched by the last read command |

## Verification
The assertions check these rules on every cycle:
- at most one counter is cleared per cycle;
- a cleared counter reads 0 on the next cycle;
- a saturated counter stays at its maximum value;
- a write while busy alters no field;
- single-cycle commands release busy after one cycle;
- the snapshot and the result register hold still unless their command runs.

Only the bench scenarios can show the following:
- the counted values after mixed increment patterns;
- the exact busy length of each command;
- that an increment is dropped only in the cycle its own counter is cleared;
- that a snapshot stays coherent while live counters move on;
- that invalid ports, unused opcodes and out-of-range indices have no effect.

// File: rtl/stat_op_pkg.sv
package stat_op_pkg;
   localparam int OP_W     = 16;
   localparam int BUSY_BIT = 15;
   localparam int OPC_LO   = 12;
   localparam int HIST_LO  = 10;
   localparam int PORT_LO  = 5;
   localparam int FIELD_W  = 5;

   typedef enum logic [2:0] {
      OPC_NONE       = 3'd0,
      OPC_FLUSH_ALL  = 3'd1,
      OPC_FLUSH_PORT = 3'd2,
      OPC_RSVD3      = 3'd3,
      OPC_READ       = 3'd4,
      OPC_CAPTURE    = 3'd5,
      OPC_RSVD6      = 3'd6,
      OPC_RSVD7      = 3'd7
   } stat_opc_e;
endpackage

// File: rtl/stat_op_seq.sv
module stat_op_seq
   import stat_op_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int NUM_CTRS  = 8,
   localparam int TOTAL    = NUM_PORTS * NUM_CTRS,
   localparam int WALK_W   = $clog2(TOTAL + 1),
   localparam int PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_wr,
   input  logic [OP_W-1:0]    op_wdata,
   output logic [OP_W-1:0]    op_rdata,
   output logic               busy,
   output logic [TOTAL-1:0]   clr_vec,
   output logic               cap_en,
   output logic [PSEL_W-1:0]  cap_port,
   output logic               rd_en,
   output logic [FIELD_W-1:0] rd_idx
);
   localparam logic [FIELD_W-1:0] PORT_MAX   = FIELD_W'(NUM_PORTS);
   localparam logic [WALK_W-1:0]  LAST_ALL   = WALK_W'(TOTAL - 1);
   localparam logic [WALK_W-1:0]  LAST_PORT  = WALK_W'(NUM_CTRS - 1);
   localparam logic [WALK_W-1:0]  CTRS_W     = WALK_W'(NUM_CTRS);

   logic               busy_q;
   stat_opc_e          opc_q;
   logic [1:0]         hist_q;
   logic [FIELD_W-1:0] port_q;
   logic [FIELD_W-1:0] idx_q;
   logic               port_ok_q;
   logic [WALK_W-1:0]  walk_q;
   logic [WALK_W-1:0]  last_q;

   stat_opc_e          wr_opc;
   logic [FIELD_W-1:0] wr_port;
   logic               wr_port_ok;
   logic [WALK_W-1:0]  wr_last;
   logic [FIELD_W-1:0] port_m1;
   logic [WALK_W-1:0]  port_base;
   logic [WALK_W-1:0]  flush_tgt;
   logic               flush_act;

   always_comb begin
      wr_opc     = stat_opc_e'(op_wdata[OPC_LO +: 3]);
      wr_port    = op_wdata[PORT_LO +: FIELD_W];
      wr_port_ok = (wr_port != '0) && (wr_port <= PORT_MAX);
      unique case (wr_opc)
         OPC_FLUSH_ALL:  wr_last = LAST_ALL;
         OPC_FLUSH_PORT: wr_last = wr_port_ok ? LAST_PORT : '0;
         default:        wr_last = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         opc_q     <= OPC_NONE;
         hist_q    <= '0;
         port_q    <= '0;
         idx_q     <= '0;
         port_ok_q <= 1'b0;
         walk_q    <= '0;
         last_q    <= '0;
      end else if (op_wr && !busy_q) begin
         hist_q <= op_wdata[HIST_LO +: 2];
         if (op_wdata[BUSY_BIT]) begin
            busy_q    <= 1'b1;
            opc_q     <= wr_opc;
            port_q    <= wr_port;
            idx_q     <= op_wdata[FIELD_W-1:0];
            port_ok_q <= wr_port_ok;
            walk_q    <= '0;
            last_q    <= wr_last;
         end
      end else if (busy_q) begin
         walk_q <= walk_q + WALK_W'(1);
         if (walk_q == last_q) busy_q <= 1'b0;
      end
   end

   always_comb begin
      port_m1   = port_q - FIELD_W'(1);
      port_base = WALK_W'(port_m1) * CTRS_W;
      flush_tgt = (opc_q == OPC_FLUSH_ALL) ? walk_q : (port_base + walk_q);
      flush_act = busy_q && ((opc_q == OPC_FLUSH_ALL) ||
                             ((opc_q == OPC_FLUSH_PORT) && port_ok_q));
   end

   for (genvar g = 0; g < TOTAL; g++) begin : g_clr
      assign clr_vec[g] = flush_act && (flush_tgt == WALK_W'(g));
   end

   assign cap_en   = busy_q && (opc_q == OPC_CAPTURE) && port_ok_q;
   assign cap_port = PSEL_W'(port_m1);
   assign rd_en    = busy_q && (opc_q == OPC_READ);
   assign rd_idx   = idx_q;
   assign busy     = busy_q;
   assign op_rdata = {busy_q, opc_q, hist_q, port_q, idx_q};

   AST_WR_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && op_wr) |=> ($stable(hist_q) && $stable(opc_q) && $stable(port_q) && $stable(idx_q))); // R4
   AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_vec)); // R6
   AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (walk_q <= last_q)); // R5
   AST_SHORT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (opc_q != OPC_FLUSH_ALL) && (opc_q != OPC_FLUSH_PORT)) |=> !busy_q); // R9
endmodule

// File: rtl/stat_ctr_bank.sv
module stat_ctr_bank #(
   parameter int TOTAL = 32,
   parameter int CTR_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [TOTAL-1:0]       inc,
   input  logic [TOTAL-1:0]       clr,
   output logic [TOTAL*CTR_W-1:0] cnt_flat
);
   localparam logic [CTR_W-1:0] CTR_MAX = '1;

   for (genvar g = 0; g < TOTAL; g++) begin : g_ctr
      logic [CTR_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n)                          cnt_q <= '0;
         else if (clr[g])                     cnt_q <= '0;
         else if (inc[g] && cnt_q != CTR_MAX) cnt_q <= cnt_q + CTR_W'(1);
      end

      assign cnt_flat[g*CTR_W +: CTR_W] = cnt_q;

      AST_CTR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q == CTR_MAX && !clr[g]) |=> (cnt_q == CTR_MAX)); // R10
      AST_CTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
         clr[g] |=> (cnt_q == '0)); // R6
   end
endmodule

// File: rtl/stat_snap_buf.sv
module stat_snap_buf
   import stat_op_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int NUM_CTRS  = 8,
   parameter int CTR_W     = 32,
   localparam int TOTAL    = NUM_PORTS * NUM_CTRS,
   localparam int PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int ISEL_W   = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [TOTAL*CTR_W-1:0] cnt_flat,
   input  logic                   cap_en,
   input  logic [PSEL_W-1:0]      cap_port,
   input  logic                   rd_en,
   input  logic [FIELD_W-1:0]     rd_idx,
   output logic [CTR_W-1:0]       rd_data
);
   localparam logic [FIELD_W:0] IDX_LIMIT = (FIELD_W+1)'(NUM_CTRS);

   logic [NUM_CTRS-1:0][CTR_W-1:0] snap_q;
   logic [CTR_W-1:0]               rd_q;
   logic [ISEL_W-1:0]              rd_sel;
   logic                           rd_ok;

   for (genvar c = 0; c < NUM_CTRS; c++) begin : g_snap
      always_ff @(posedge clk) begin
         if (!rst_n)      snap_q[c] <= '0;
         else if (cap_en) snap_q[c] <= cnt_flat[(int'(cap_port) * NUM_CTRS + c) * CTR_W +: CTR_W];
      end
   end

   assign rd_sel = ISEL_W'(rd_idx);
   assign rd_ok  = {1'b0, rd_idx} < IDX_LIMIT;

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= rd_ok ? snap_q[rd_sel] : '0;
   end

   assign rd_data = rd_q;

   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(snap_q)); // R7
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_q)); // R8
endmodule

// File: rtl/stat_op_ctrl.sv
module stat_op_ctrl
   import stat_op_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int NUM_CTRS  = 8,
   parameter int CTR_W     = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          op_wr,
   input  logic [15:0]                   op_wdata,
   output logic [15:0]                   op_rdata,
   output logic                          busy,
   input  logic [NUM_PORTS*NUM_CTRS-1:0] inc,
   output logic [CTR_W-1:0]              rd_data
);
   localparam int TOTAL  = NUM_PORTS * NUM_CTRS;
   localparam int PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

   if (NUM_PORTS < 1 || NUM_PORTS > 31) begin : g_bad_ports
      $error("NUM_PORTS must fit the port field as port+1");
   end
   if (NUM_CTRS < 1 || NUM_CTRS > 32) begin : g_bad_ctrs
      $error("NUM_CTRS must fit the index field");
   end
   if (CTR_W < 1) begin : g_bad_width
      $error("CTR_W must be positive");
   end

   logic [TOTAL-1:0]       clr_vec;
   logic                   cap_en;
   logic [PSEL_W-1:0]      cap_port;
   logic                   rd_en;
   logic [FIELD_W-1:0]     rd_idx;
   logic [TOTAL*CTR_W-1:0] cnt_flat;

   stat_op_seq #(.NUM_PORTS(NUM_PORTS), .NUM_CTRS(NUM_CTRS)) u_seq (
      .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_wdata(op_wdata),
      .op_rdata(op_rdata), .busy(busy), .clr_vec(clr_vec),
      .cap_en(cap_en), .cap_port(cap_port), .rd_en(rd_en), .rd_idx(rd_idx)
   );

   stat_ctr_bank #(.TOTAL(TOTAL), .CTR_W(CTR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .inc(inc), .clr(clr_vec), .cnt_flat(cnt_flat)
   );

   stat_snap_buf #(.NUM_PORTS(NUM_PORTS), .NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W)) u_snap (
      .clk(clk), .rst_n(rst_n), .cnt_flat(cnt_flat), .cap_en(cap_en),
      .cap_port(cap_port), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data)
   );

   AST_NO_START_WHEN_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && op_wr && !op_wdata[BUSY_BIT]) |=> !busy); // R3
endmodule

// File: tb/stat_op_ctrl_tb.sv
`timescale 1ns/1ps
module stat_op_ctrl_tb;
   localparam int N   = 3;
   localparam int C   = 4;
   localparam int W   = 4;
   localparam int MAXV = (1 << W) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_wr = 1'b0;
   logic [15:0]   op_wdata = '0;
   logic [15:0]   op_rdata;
   logic          busy;
   logic [N*C-1:0] inc = '0;
   logic [W-1:0]  rd_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   int exp_cnt[N][C];
   int exp_snap[C];

   always #2.5 clk = ~clk;

   stat_op_ctrl #(.NUM_PORTS(N), .NUM_CTRS(C), .CTR_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_wdata(op_wdata),
      .op_rdata(op_rdata), .busy(busy), .inc(inc), .rd_data(rd_data)
   );

   function automatic logic [15:0] mk(int st, int op, int hist, int pf, int idx);
      return {1'(st), 3'(op), 2'(hist), 5'(pf), 5'(idx)};
   endfunction

   task automatic check(string req, int act, int expv, string what);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic bump(int p, int c);
      if (exp_cnt[p][c] < MAXV) exp_cnt[p][c]++;
   endtask

   task automatic issue(logic [15:0] w, output int cycles);
      @(negedge clk);
      op_wr = 1'b1;
      op_wdata = w;
      @(negedge clk);
      op_wr = 1'b0;
      cycles = 0;
      while (busy && cycles < 500) begin
         cycles++;
         @(negedge clk);
      end
   endtask

   task automatic capture_read(int p, string req);
      int cy;
      issue(mk(1, 5, 0, p + 1, 0), cy);
      check("R7", cy, 1, "capture busy cycles");
      for (int c = 0; c < C; c++) exp_snap[c] = exp_cnt[p][c];
      for (int c = 0; c < C; c++) begin
         issue(mk(1, 4, 0, 0, c), cy);
         check("R8", cy, 1, "read busy cycles");
         check(req, int'(rd_data), exp_cnt[p][c], $sformatf("port %0d counter %0d", p, c));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int cy;
      for (int p = 0; p < N; p++) for (int c = 0; c < C; c++) exp_cnt[p][c] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", int'(busy), 0, "busy after reset");
      check("R1", int'(op_rdata), 0, "op_rdata after reset");
      check("R1", int'(rd_data), 0, "rd_data after reset");
      capture_read(0, "R1");

      // R10 mixed increment pattern over all counters
      for (int t = 0; t < 7; t++) begin
         @(negedge clk);
         for (int p = 0; p < N; p++) for (int c = 0; c < C; c++) begin
            if (t < ((p * C + c) % 7) + 1) begin
               inc[p*C+c] = 1'b1;
               bump(p, c);
            end else inc[p*C+c] = 1'b0;
         end
      end
      @(negedge clk);
      inc = '0;
      for (int p = 0; p < N; p++) capture_read(p, "R10");

      // R10 saturation
      @(negedge clk);
      inc[1*C+2] = 1'b1;
      repeat (20) begin
         bump(1, 2);
         @(negedge clk);
      end
      inc = '0;
      capture_read(1, "R10");

      // R7 snapshot coherent while counters move on
      capture_read(2, "R7");
      @(negedge clk);
      inc[2*C+0] = 1'b1;
      bump(2, 0);
      @(negedge clk);
      inc = '0;
      issue(mk(1, 4, 0, 0, 0), cy);
      check("R7", int'(rd_data), exp_snap[0], "snapshot after later increment");

      // R9 unused opcodes and bad port fields
      foreach (exp_snap[i]) begin end
      begin
         int ops[4] = '{0, 3, 6, 7};
         for (int k = 0; k < 4; k++) begin
            issue(mk(1, ops[k], 0, 2, 1), cy);
            check("R9", cy, 1, $sformatf("opcode %0d busy cycles", ops[k]));
         end
      end
      issue(mk(1, 5, 0, 0, 0), cy);
      check("R9", cy, 1, "capture port field 0 busy cycles");
      issue(mk(1, 5, 0, N + 1, 0), cy);
      check("R9", cy, 1, "capture port field too large busy cycles");
      issue(mk(1, 2, 0, 0, 0), cy);
      check("R9", cy, 1, "flush port field 0 busy cycles");
      issue(mk(1, 2, 0, N + 1, 0), cy);
      check("R9", cy, 1, "flush port field too large busy cycles");
      for (int c = 0; c < C; c++) begin
         issue(mk(1, 4, 0, 0, c), cy);
         check("R9", int'(rd_data), exp_snap[c], $sformatf("snapshot kept entry %0d", c));
      end
      for (int p = 0; p < N; p++) capture_read(p, "R9");

      // R8 out-of-range index
      issue(mk(1, 4, 0, 0, C), cy);
      check("R8", int'(rd_data), 0, "index NUM_CTRS");
      issue(mk(1, 4, 0, 0, 31), cy);
      check("R8", int'(rd_data), 0, "index 31");

      // R2 readback of the command fields
      issue(mk(1, 4, 2, 3, 2), cy);
      check("R2", int'(op_rdata), int'(mk(0, 4, 2, 3, 2)), "op_rdata after read");

      // R6 flush of port 0 with increments during the walk
      @(negedge clk);
      op_wr = 1'b1;
      op_wdata = mk(1, 2, 0, 1, 0);
      @(negedge clk);
      op_wr = 1'b0;
      cy = 0;
      while (busy && cy < 500) begin
         if (cy == 3) begin
            inc[0*C+3] = 1'b1;
            inc[0*C+1] = 1'b1;
            inc[2*C+0] = 1'b1;
         end else inc = '0;
         cy++;
         @(negedge clk);
      end
      inc = '0;
      check("R6", cy, C, "flush port busy cycles");
      for (int c = 0; c < C; c++) exp_cnt[0][c] = 0;
      exp_cnt[0][1] = 1;
      bump(2, 0);
      for (int p = 0; p < N; p++) capture_read(p, "R6");

      // R4 and R5 flush all with a write while busy
      @(negedge clk);
      op_wr = 1'b1;
      op_wdata = mk(1, 1, 1, 0, 0);
      @(negedge clk);
      op_wdata = mk(1, 5, 3, 2, 1);
      cy = 1;
      @(negedge clk);
      op_wr = 1'b0;
      while (busy && cy < 500) begin
         cy++;
         @(negedge clk);
      end
      check("R5", cy, N * C, "flush all busy cycles");
      check("R4", int'(op_rdata[11:10]), 1, "histogram after busy write");
      check("R4", int'(op_rdata[14:12]), 1, "opcode after busy write");
      for (int p = 0; p < N; p++) for (int c = 0; c < C; c++) exp_cnt[p][c] = 0;
      for (int p = 0; p < N; p++) capture_read(p, "R5");

      // R3 histogram setting
      issue(mk(0, 5, 2, 1, 0), cy);
      check("R3", cy, 0, "write without start busy cycles");
      check("R3", int'(op_rdata[11:10]), 2, "histogram from plain write");
      issue(mk(1, 1, 3, 0, 0), cy);
      check("R3", int'(op_rdata[11:10]), 3, "histogram kept through command");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule